// File: doc/BRIEF.md
# Flash Memory Erase and Write Controller

This block sits in front of a word-organised NOR-style storage array and a small bank of user configuration words. Software drives it through a 32-bit register port. That port holds a configuration register with separate write and erase enables, a ready flag, and three erase commands. The commands erase one page, erase everything, or erase the user words. A second port carries word writes into the array, and a write can only clear bits.

The array is an internal memory whose size and page size are parameters. Page and full erases run as a counter that fills one word with ones on each clock. While that counter runs the block reports not-ready and drops further writes and commands. The user word bank is a set of flops that is cleared to ones in a single cycle. A misuse, such as writing while a gate is shut or addressing a hole in the register map, raises a one-cycle error pulse and changes no state.

Top module: `flash_erase_ctrl`

## Requirements
- R1: The configuration register sits at control offset 0x04. Bit 0 is write enable and bit 1 is erase enable. A write keeps only those two bits, the other bits read back as zero, and the register resets to zero.
- R2: While write enable is set, an array write stores the old word ANDed with the new data, so no bit can go from 0 back to 1.
- R3: While write enable is clear, an array write leaves the array unchanged and raises errPulse for one cycle.
- R4: The page erase command sits at control offset 0x08 and carries a byte address. The in-page offset bits of that address are cleared. If erase enable is set and the whole page lies inside the array, every word of that page becomes all-ones and no other word changes. If the page lies outside the array, the command is ignored.
- R5: A page erase issued while erase enable is clear raises errPulse and changes nothing.
- R6: The full erase command sits at control offset 0x0C. When the written value is 32'h1 and erase enable is set, every array word and every user word becomes all-ones. Any other value, or a clear erase enable, is ignored.
- R7: The user erase command sits at control offset 0x10. When the written value is 32'h1, all user words become all-ones whatever the state of erase enable, and any other value is ignored.
- R8: After reset the configuration reads zero, ready reads 1, and every user word reads all-ones.
- R9: With regUser high, the port reads and writes the user words at word-aligned byte offsets 0x00 to 0xFC.
- R10: The ready register sits at control offset 0x00. Once a page erase starts, it reads 0 for exactly one cycle per page word and then reads 1. Array writes and register writes issued during that time are dropped.
- R11: Reads from undefined control offsets return zero. A write to an undefined or read-only control offset raises errPulse and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regUser | input | 1 | 1 selects the user word window, 0 selects the control registers |
| regWe | input | 1 | Register port write strobe |
| regAddr | input | 8 | Register port byte offset |
| regWdata | input | 32 | Register port write data |
| regRdata | output | 32 | Register port read data (combinational) |
| arrWe | input | 1 | Array write strobe |
| arrAddr | input | ARR_AW | Array byte address (word aligned) |
| arrWdata | input | 32 | Array write data |
| arrRdata | output | 32 | Array word at arrAddr (combinational) |
| errPulse | output | 1 | One-cycle error indication |

## Verification
The bench builds the block with a 2 KiB array and 256-byte pages. That gives eight pages of 64 words, so a full erase takes 512 cycles. With that size the bench can hold a complete shadow copy of the array and compare every word after each erase. It can also aim page erases at the first page, the last page and the first address past the end. Random writes fall on words that earlier writes have already touched, so the one-way clearing of bits is exercised again and again.

// File: rtl/fec_pkg.sv
package fec_pkg;
  localparam logic [7:0] OFS_READY  = 8'h00;
  localparam logic [7:0] OFS_CFG    = 8'h04;
  localparam logic [7:0] OFS_ERPAGE = 8'h08;
  localparam logic [7:0] OFS_ERALL  = 8'h0C;
  localparam logic [7:0] OFS_ERUSER = 8'h10;
  localparam logic [31:0] ERASE_KEY = 32'h0000_0001;

  typedef struct packed {
    logic arrWrite;   // AND new data into the addressed array word
    logic userWrite;  // store a user word
    logic userClear;  // set every user word to ones
    logic wipeWord;   // set array word at eraseIdx to ones
  } fec_strobe_t;
endpackage

// File: rtl/fec_ctrl.sv
module fec_ctrl
  import fec_pkg::*;
#(
  parameter int ARRAY_BYTES = 8192,
  parameter int PAGE_BYTES  = 1024,
  localparam int ARRAY_WORDS = ARRAY_BYTES / 4,
  localparam int PAGE_WORDS  = PAGE_BYTES / 4,
  localparam int IDX_W       = $clog2(ARRAY_WORDS),
  localparam int ARR_AW      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regUser,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              arrWe,
  output fec_strobe_t       strobe,
  output logic [IDX_W-1:0]  eraseIdx,
  output logic [1:0]        cfg,
  output logic              busy,
  output logic              errPulse
);
  localparam logic [31:0] PAGE_MASK = ~(32'(PAGE_BYTES) - 32'd1);
  localparam logic [31:0] LAST_PAGE = 32'(ARRAY_BYTES - PAGE_BYTES);

  logic [IDX_W-1:0] eraseLast;
  logic [31:0]      pageAddr;
  logic             pageInRange;
  logic             wen, een;
  logic             ctlWrite;
  logic             startPage, startAll, cfgWrite, errNext;
  logic [IDX_W-1:0] pageFirst;

  assign wen         = cfg[0];
  assign een         = cfg[1];
  assign ctlWrite    = regWe && !regUser && !busy;
  assign pageAddr    = regWdata & PAGE_MASK;
  assign pageInRange = pageAddr <= LAST_PAGE;
  assign pageFirst   = pageAddr[ARR_AW-1:2];

  always_comb begin
    strobe    = '0;
    startPage = 1'b0;
    startAll  = 1'b0;
    cfgWrite  = 1'b0;
    errNext   = 1'b0;
    strobe.wipeWord = busy;
    if (!busy) begin
      if (arrWe) begin
        if (wen) strobe.arrWrite = 1'b1;
        else     errNext = 1'b1;
      end
      if (regWe && regUser) strobe.userWrite = 1'b1;
    end
    if (ctlWrite) begin
      case (regAddr)
        OFS_CFG: cfgWrite = 1'b1;
        OFS_ERPAGE: begin
          if (!een)             errNext = 1'b1;
          else if (pageInRange) startPage = 1'b1;
        end
        OFS_ERALL: begin
          if (een && regWdata == ERASE_KEY) begin
            startAll         = 1'b1;
            strobe.userClear = 1'b1;
          end
        end
        OFS_ERUSER: begin
          if (regWdata == ERASE_KEY) strobe.userClear = 1'b1;
        end
        default: errNext = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= 2'b00;
      busy      <= 1'b0;
      eraseIdx  <= '0;
      eraseLast <= '0;
      errPulse  <= 1'b0;
    end else begin
      errPulse <= errNext;
      if (cfgWrite) cfg <= regWdata[1:0];
      if (startPage) begin
        busy      <= 1'b1;
        eraseIdx  <= pageFirst;
        eraseLast <= pageFirst + IDX_W'(PAGE_WORDS - 1);
      end else if (startAll) begin
        busy      <= 1'b1;
        eraseIdx  <= '0;
        eraseLast <= IDX_W'(ARRAY_WORDS - 1);
      end else if (busy) begin
        if (eraseIdx == eraseLast) busy <= 1'b0;
        else eraseIdx <= eraseIdx + 1'b1;
      end
    end
  end

  // R1: a configuration write lands with only the two enable bits
  assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !regUser && !busy && regAddr == OFS_CFG) |=> cfg == $past(regWdata[1:0]));

  // R3: an array write with write enable clear is flagged
  assert_wr_locked_err_R3: assert property (@(posedge clk) disable iff (!rstN)
    (arrWe && !busy && !cfg[0]) |=> errPulse);

  // R10: the erase walk ends only on its last word
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(eraseIdx == eraseLast));

  // R10: the walk never runs past its last word
  assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> eraseIdx <= eraseLast);

  // R5: page erase with erase disabled is flagged and starts nothing
  assert_page_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrite && regAddr == OFS_ERPAGE && !cfg[1]) |=> (errPulse && !busy));
endmodule

// File: rtl/fec_datapath.sv
module fec_datapath
  import fec_pkg::*;
#(
  parameter int ARRAY_WORDS = 2048,
  parameter int USER_WORDS  = 64,
  localparam int IDX_W = $clog2(ARRAY_WORDS),
  localparam int UAW   = $clog2(USER_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fec_strobe_t       strobe,
  input  logic [IDX_W-1:0]  arrIdx,
  input  logic [31:0]       arrWdata,
  input  logic [IDX_W-1:0]  eraseIdx,
  input  logic [UAW-1:0]    userIdx,
  input  logic [31:0]       userWdata,
  output logic [31:0]       arrRdata,
  output logic [31:0]       userRdata
);
  logic [31:0] store [ARRAY_WORDS];
  logic [31:0] userWord [USER_WORDS];

  always_ff @(posedge clk) begin
    if (strobe.wipeWord)
      store[eraseIdx] <= '1;
    else if (strobe.arrWrite)
      store[arrIdx] <= store[arrIdx] & arrWdata;
  end

  for (genvar g = 0; g < USER_WORDS; g++) begin : gUser
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        userWord[g] <= '1;
      else if (strobe.userClear)
        userWord[g] <= '1;
      else if (strobe.userWrite && userIdx == UAW'(g))
        userWord[g] <= userWdata;
    end
  end

  assign arrRdata  = store[arrIdx];
  assign userRdata = userWord[userIdx];

  // R2: a program step never raises a bit
  assert_no_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.arrWrite && !strobe.wipeWord) |=>
      (store[$past(arrIdx)] & ~$past(store[arrIdx])) == 32'h0);

  // R4: each erase step leaves its word at all-ones
  assert_wipe_ones_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipeWord |=> store[$past(eraseIdx)] == 32'hFFFF_FFFF);

  // R7: a user clear leaves the first and last user words at all-ones
  assert_user_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.userClear |=> (userWord[0] == '1 && userWord[USER_WORDS-1] == '1));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fec_pkg::*;
#(
  parameter int ARRAY_BYTES = 8192,
  parameter int PAGE_BYTES  = 1024,
  parameter int USER_WORDS  = 64,
  localparam int ARRAY_WORDS = ARRAY_BYTES / 4,
  localparam int IDX_W       = $clog2(ARRAY_WORDS),
  localparam int ARR_AW      = $clog2(ARRAY_BYTES),
  localparam int UAW         = $clog2(USER_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regUser,
  input  logic              regWe,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              arrWe,
  input  logic [ARR_AW-1:0] arrAddr,
  input  logic [31:0]       arrWdata,
  output logic [31:0]       arrRdata,
  output logic              errPulse
);
  fec_strobe_t      strobe;
  logic [IDX_W-1:0] eraseIdx;
  logic [1:0]       cfg;
  logic             busy;
  logic [31:0]      userRdata;

  fec_ctrl #(.ARRAY_BYTES(ARRAY_BYTES), .PAGE_BYTES(PAGE_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .regUser(regUser), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .arrWe(arrWe),
    .strobe(strobe), .eraseIdx(eraseIdx), .cfg(cfg), .busy(busy),
    .errPulse(errPulse)
  );

  fec_datapath #(.ARRAY_WORDS(ARRAY_WORDS), .USER_WORDS(USER_WORDS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .arrIdx(arrAddr[ARR_AW-1:2]), .arrWdata(arrWdata),
    .eraseIdx(eraseIdx), .userIdx(regAddr[UAW+1:2]),
    .userWdata(regWdata), .arrRdata(arrRdata), .userRdata(userRdata)
  );

  always_comb begin
    regRdata = 32'h0;
    if (regUser) regRdata = userRdata;
    else begin
      case (regAddr)
        OFS_READY: regRdata = {31'h0, !busy};
        OFS_CFG:   regRdata = {30'h0, cfg};
        default:   regRdata = 32'h0;
      endcase
    end
  end

  // R11: an undefined control offset reads as zero
  assert_hole_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!regUser && regAddr > OFS_CFG) |-> regRdata == 32'h0);
endmodule

// File: tb/flash_erase_ctrl_test.sv
`timescale 1ns/1ps
module flash_erase_ctrl_test;
  localparam int AB = 2048, PB = 256, UW = 64;
  localparam int NW = AB / 4, PW = PB / 4;
  localparam int AW = $clog2(AB);

  logic clk = 0, rstN = 0;
  logic regUser = 0, regWe = 0, arrWe = 0;
  logic [7:0] regAddr = 0;
  logic [31:0] regWdata = 0, arrWdata = 0, regRdata, arrRdata;
  logic [AW-1:0] arrAddr = 0;
  logic errPulse;
  int vecs = 0, bad = 0;
  logic [31:0] mArr [NW];
  logic [31:0] mUser [UW];
  logic lastErr;

  always #2 clk = ~clk;

  flash_erase_ctrl #(.ARRAY_BYTES(AB), .PAGE_BYTES(PB), .USER_WORDS(UW)) uut (
    .clk(clk), .rstN(rstN), .regUser(regUser), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .arrWe(arrWe), .arrAddr(arrAddr),
    .arrWdata(arrWdata), .arrRdata(arrRdata), .errPulse(errPulse));

  function automatic logic [31:0] progWord(logic [31:0] o, logic [31:0] n);
    return o & n;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic regWr(logic u, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regUser = u; regAddr = a; regWdata = d; regWe = 1;
    @(posedge clk); #1;
    regWe = 0; lastErr = errPulse;
  endtask

  task automatic regRd(logic u, logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regUser = u; regAddr = a; #1; d = regRdata;
  endtask

  task automatic arrWr(int w, logic [31:0] d);
    @(negedge clk);
    arrAddr = AW'(w * 4); arrWdata = d; arrWe = 1;
    @(posedge clk); #1;
    arrWe = 0; lastErr = errPulse;
  endtask

  task automatic arrRd(int w, output logic [31:0] d);
    @(negedge clk);
    arrAddr = AW'(w * 4); #1; d = arrRdata;
  endtask

  // counts not-ready cycles after a command has just been clocked in
  task automatic waitReady(output int n);
    n = 0;
    regUser = 0; regAddr = 8'h00; #0.1;
    while (regRdata[0] == 1'b0 && n < 5000) begin
      n++; @(posedge clk); #1;
    end
  endtask

  task automatic cmpAll(string req);
    logic [31:0] d;
    int errs = 0;
    for (int i = 0; i < NW; i++) begin
      arrRd(i, d);
      if (d !== mArr[i]) begin
        errs++;
        if (errs == 1) $display("FAIL %s word %0d got=%h exp=%h", req, i, d, mArr[i]);
      end
    end
    vecs++; if (errs != 0) bad++;
  endtask

  task automatic cmpUser(string req);
    logic [31:0] d;
    int errs = 0;
    for (int i = 0; i < UW; i++) begin
      regRd(1, 8'(i * 4), d);
      if (d !== mUser[i]) begin
        errs++;
        if (errs == 1) $display("FAIL %s user %0d got=%h exp=%h", req, i, d, mUser[i]);
      end
    end
    vecs++; if (errs != 0) bad++;
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    $display("FAIL watchdog got=%h exp=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < UW; i++) mUser[i] = '1;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R8 reset state
    regRd(0, 8'h04, d); check("R8 cfg", d, 0);
    regRd(0, 8'h00, d); check("R8 ready", d, 1);
    cmpUser("R8 user");

    // R1 masking
    regWr(0, 8'h04, 32'hFFFF_FFFE);
    regRd(0, 8'h04, d); check("R1 cfg mask", d, 32'h2);

    // R6 full erase brings array to known ones; user words too
    regWr(1, 8'h20, 32'h1234_5678); mUser[8] = 32'h1234_5678;
    regWr(0, 8'h0C, 32'h1);
    waitReady(n); check("R6 cycles", n, NW);
    for (int i = 0; i < NW; i++) mArr[i] = '1;
    for (int i = 0; i < UW; i++) mUser[i] = '1;
    cmpAll("R6 array"); cmpUser("R6 user");

    // R3 write while write enable clear
    arrWr(5, 32'h0); check("R3 err", 32'(lastErr), 1);
    arrRd(5, d); check("R3 unchanged", d, 32'hFFFF_FFFF);

    // R2 random programming + R9 random user access
    regWr(0, 8'h04, 32'h3);
    for (int k = 0; k < 400; k++) begin
      int w = $urandom_range(0, 40);
      logic [31:0] v = $urandom;
      case ($urandom_range(0, 3))
        0: begin arrWr(w, v); mArr[w] = progWord(mArr[w], v);
                 check("R2 no err", 32'(lastErr), 0); end
        1: begin arrRd(w, d); check("R2 readback", d, mArr[w]); end
        2: begin regWr(1, 8'(w * 4), v); mUser[w] = v; end
        default: begin regRd(1, 8'(w * 4), d); check("R9 user", d, mUser[w]); end
      endcase
    end
    arrWr(NW - 1, 32'h0F0F_0000); mArr[NW-1] = 32'h0F0F_0000;
    arrWr(NW - 1, 32'hFF00_FFFF); mArr[NW-1] = 32'h0F00_0000;
    arrRd(NW - 1, d); check("R2 last word", d, 32'h0F00_0000);

    // R4 page erase of page 0 via unaligned address, last page too
    regWr(0, 8'h08, 32'h0000_0033);
    waitReady(n); check("R10 page cycles", n, PW);
    for (int i = 0; i < PW; i++) mArr[i] = '1;
    regWr(0, 8'h08, 32'(AB - PB + 4));
    waitReady(n); check("R4 last page", n, PW);
    for (int i = NW - PW; i < NW; i++) mArr[i] = '1;
    cmpAll("R4 pages");

    // R4 out of range ignored
    arrWr(NW - 1, 32'h0); mArr[NW-1] = 0;
    regWr(0, 8'h08, 32'(AB));
    check("R4 oor no err", 32'(lastErr), 0);
    regRd(0, 8'h00, d); check("R4 oor ready", d, 1);
    arrRd(NW - 1, d); check("R4 oor kept", d, 0);

    // R10 writes dropped while busy
    arrWr(PW + 1, 32'h0); mArr[PW+1] = 0;
    regWr(0, 8'h08, 32'(PB));
    arrWr(0, 32'h0);
    regWr(0, 8'h04, 32'h0);
    waitReady(n);
    for (int i = PW; i < 2 * PW; i++) mArr[i] = '1;
    arrRd(0, d); check("R10 drop arr", d, mArr[0]);
    regRd(0, 8'h04, d); check("R10 drop cfg", d, 3);

    // R6 bad key ignored
    regWr(0, 8'h0C, 32'h2);
    regRd(0, 8'h00, d); check("R6 bad key", d, 1);
    arrRd(NW - 1, d); check("R6 bad key arr", d, 0);

    // R5 page erase with erase disabled
    regWr(0, 8'h04, 32'h1);
    regWr(0, 8'h08, 32'h0);
    check("R5 err", 32'(lastErr), 1);
    regRd(0, 8'h00, d); check("R5 ready", d, 1);
    // R6 full erase with erase disabled ignored
    regWr(0, 8'h0C, 32'h1);
    regRd(0, 8'h00, d); check("R6 gated", d, 1);
    cmpAll("R5 R6 array kept");

    // R7 user erase: bad key ignored, good key works with erase disabled
    regWr(1, 8'hFC, 32'h0); mUser[63] = 0;
    regWr(0, 8'h10, 32'h5);
    regRd(1, 8'hFC, d); check("R7 bad key", d, 0);
    regWr(0, 8'h10, 32'h1);
    for (int i = 0; i < UW; i++) mUser[i] = '1;
    cmpUser("R7 user");

    // R11 holes
    regRd(0, 8'h44, d); check("R11 rd hole", d, 0);
    regWr(0, 8'h44, 32'hFFFF_FFFF); check("R11 wr hole err", 32'(lastErr), 1);
    regWr(0, 8'h00, 32'h0); check("R11 ready ro err", 32'(lastErr), 1);
    regRd(0, 8'h04, d); check("R11 cfg kept", d, 1);
    regRd(0, 8'h00, d); check("R11 ready", d, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule